// File: doc/BRIEF.md
# Vector Group Decode-Progress Register

This block holds a 32-bit control/status word that follows a processor through one variable-length vector instruction group. The fetch and decode path reports milestones as single-cycle strobes: a group header recognised, the vector-length block decoded, the predicate and register blocks decoded, an opcode retired with its length, and the final opcode finished. The register records the milestones in a two-bit phase field. The field only moves forward, so a single-issue core never has to buffer the whole group before it starts to execute.

Once the group is executing, a 5-bit in-group pointer counts 16-bit units from the first opcode. Software may redirect that pointer through a CSR write, in immediate or register form. A write is accepted only in the executing phase and only when the value is below a bound that the decoder supplies. On trap entry the whole word is copied into a saved register, which the trap handler may overwrite freely. On trap return the word comes back from that copy. An executing group is rolled back one phase so that its register blocks are decoded again, while the pointer is kept.

Top module: `vgrp_state_csr`

## Requirements
- R1: During and right after reset, `csr_value` and `saved_value` are 0, `grp_active` is 0 and `illegal_o` is 0.
- R2: The word is laid out as phase[31:30], lenset[29], ilen16[28:26], predlen[25:24], reglen[23:22], mode[21], lenblk[20:5], optr[4:0]. The phase codes are 00 scalar, 01 header captured, 10 length decoded and 11 executing. `csr_value` always returns all 32 bits, and `grp_active` is 1 exactly when the phase is not 00.
- R3: `hdr_seen` in phase 00 gives phase 01 one cycle later. The header fields take `hdr_fields` (bit 8 lenset, 7:5 ilen16, 4:3 predlen, 2:1 reglen, 0 mode), and lenblk and optr become 0. In any other phase `hdr_seen` has no effect.
- R4: `lenblk_done` in phase 01 gives phase 10 with lenblk set to `lenblk_val`. It has no effect in any other phase.
- R5: `regblk_done` in phase 10 gives phase 11 and leaves optr unchanged. It has no effect in any other phase.
- R6: `op_retire` in phase 11 adds `op_len` to optr, modulo 32.
- R7: `last_done` in phase 11 clears the whole word to 0. It takes priority over `op_retire`.
- R8: A CSR write in phase 11 whose value is below `ptr_bound` replaces optr and leaves the other 27 bits alone. The immediate form (`wr_use_imm`=1) uses `wr_imm`. The register form compares the whole 32-bit `wr_rs1` and then stores its low 5 bits.
- R9: A CSR write in a phase other than 11, or with a value greater than or equal to `ptr_bound`, leaves the word unchanged and raises `illegal_o` for exactly the next cycle.
- R10: `trap_enter` copies the word into `saved_value` and clears the word to 0.
- R11: `trap_return` loads the word from `saved_value`. A saved phase of 11 comes back as 10 with optr preserved, and a following `regblk_done` resumes phase 11 at the same optr. Any other saved phase is restored unchanged.
- R12: `sv_wr` loads `sv_wdata` into `saved_value` with no legality check and never raises `illegal_o`. `trap_enter` in the same cycle takes priority over it.
- R13: When strobes coincide, the order of precedence is `trap_enter`, then `trap_return`, then the CSR write, then the phase strobes. A write that loses to a trap strobe raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_seen | input | 1 | Start of a valid vector group recognised |
| hdr_fields | input | 9 | Header fields {lenset, ilen16, predlen, reglen, mode} |
| lenblk_done | input | 1 | Vector-length block decoded |
| lenblk_val | input | 16 | Decoded vector-length block |
| regblk_done | input | 1 | Predicate and register blocks decoded |
| op_retire | input | 1 | One in-group opcode retired |
| op_len | input | 3 | Length of the retired opcode in 16-bit units |
| last_done | input | 1 | Final opcode of the group completed |
| trap_enter | input | 1 | Trap taken |
| trap_return | input | 1 | Return from trap |
| csr_wr | input | 1 | Pointer write request |
| wr_use_imm | input | 1 | 1 selects the immediate form, 0 the register form |
| wr_imm | input | 5 | Immediate pointer value |
| wr_rs1 | input | 32 | Register-form source value |
| ptr_bound | input | 6 | Opcode range of the group in 16-bit units; a pointer is legal below it |
| sv_wr | input | 1 | Write to the saved copy |
| sv_wdata | input | 32 | Data for the saved copy |
| csr_value | output | 32 | Full live register |
| grp_active | output | 1 | Phase is not scalar |
| cur_optr | output | 5 | In-group opcode pointer |
| illegal_o | output | 1 | Illegal-instruction pulse for a rejected write |
| saved_value | output | 32 | Saved trap copy |

## Verification
The properties do not assume that strobes are mutually exclusive. Each one is qualified by the absence of the higher-priority events, so it relies only on the precedence order of R13. The bench stimulus deliberately overlaps strobes, traps and writes in the same cycle. It keeps `ptr_bound` within 0 to 32 and `op_len` within 1 to 4, the range of real opcode lengths. Register-form values are drawn both as small numbers near the bound and as full 32-bit values, so that a value whose high bits are set but whose low five bits look legal is rejected.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;
    localparam int XLEN    = 32;
    localparam int PTR_W   = 5;
    localparam int LEN_W   = 16;
    localparam int ILEN_W  = 3;
    localparam int PLEN_W  = 2;
    localparam int RLEN_W  = 2;
    localparam int OPLEN_W = 3;
    localparam int HDR_W   = 1 + ILEN_W + PLEN_W + RLEN_W + 1;
    localparam int BND_W   = PTR_W + 1;

    typedef enum logic [1:0] {
        PH_SCALAR = 2'b00,
        PH_HDR    = 2'b01,
        PH_LEN    = 2'b10,
        PH_EXEC   = 2'b11
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic                lenset;
        logic [ILEN_W-1:0]   ilen16;
        logic [PLEN_W-1:0]   predlen;
        logic [RLEN_W-1:0]   reglen;
        logic                mode;
        logic [LEN_W-1:0]    lenblk;
        logic [PTR_W-1:0]    optr;
    } vstate_t;

    // Resume form of a saved word: an executing group re-decodes its register blocks.
    function automatic vstate_t resume_form(vstate_t s);
        vstate_t r;
        r = s;
        if (s.phase == PH_EXEC)
            r.phase = PH_LEN;
        return r;
    endfunction

    function automatic logic [PTR_W-1:0] advance_ptr(logic [PTR_W-1:0] p,
                                                     logic [OPLEN_W-1:0] n);
        return p + PTR_W'(n);
    endfunction
endpackage

// File: rtl/vgrp_wr_check.sv
module vgrp_wr_check
    import vgrp_pkg::*;
(
    input  phase_e             phase,
    input  logic               use_imm,
    input  logic [PTR_W-1:0]   imm,
    input  logic [XLEN-1:0]    rs1,
    input  logic [BND_W-1:0]   bound,
    output logic               accept,
    output logic [PTR_W-1:0]   new_ptr
);
    logic [XLEN-1:0] cand;
    logic            in_range;

    always_comb begin
        cand     = use_imm ? {{(XLEN-PTR_W){1'b0}}, imm} : rs1;
        in_range = cand < {{(XLEN-BND_W){1'b0}}, bound};
        accept   = (phase == PH_EXEC) && in_range;
        new_ptr  = cand[PTR_W-1:0];
    end
endmodule

// File: rtl/vgrp_trap_save.sv
module vgrp_trap_save
    import vgrp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trap_enter,
    input  vstate_t   live_in,
    input  logic      sv_wr,
    input  vstate_t   sv_wdata,
    output vstate_t   saved,
    output vstate_t   restore_val
);
    vstate_t saved_q;

    always_ff @(posedge clk) begin
        if (rst)
            saved_q <= '0;
        else if (trap_enter)
            saved_q <= live_in;
        else if (sv_wr)
            saved_q <= sv_wdata;
    end

    assign saved       = saved_q;
    assign restore_val = resume_form(saved_q);

    // R10: entry captures the live word as it stood
    a_r10_capture: assert property (@(posedge clk) disable iff (rst)
        trap_enter |=> (saved_q == $past(live_in)));
    // R12: a handler write lands unless a trap entry preempts it
    a_r12_free_write: assert property (@(posedge clk) disable iff (rst)
        (sv_wr && !trap_enter) |=> (saved_q == $past(sv_wdata)));
endmodule

// File: rtl/vgrp_phase_fsm.sv
module vgrp_phase_fsm
    import vgrp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hdr_seen,
    input  logic [HDR_W-1:0]   hdr_fields,
    input  logic               lenblk_done,
    input  logic [LEN_W-1:0]   lenblk_val,
    input  logic               regblk_done,
    input  logic               op_retire,
    input  logic [OPLEN_W-1:0] op_len,
    input  logic               last_done,
    input  logic               trap_enter,
    input  logic               trap_return,
    input  vstate_t            restore_val,
    input  logic               csr_wr,
    input  logic               wr_ok,
    input  logic [PTR_W-1:0]   wr_ptr,
    output vstate_t            live,
    output logic               illegal
);
    vstate_t live_q, nxt;
    logic    illegal_q, reject;

    always_comb begin
        nxt    = live_q;
        reject = 1'b0;
        if (trap_enter) begin
            nxt = '0;
        end else if (trap_return) begin
            nxt = restore_val;
        end else if (csr_wr) begin
            if (wr_ok) nxt.optr = wr_ptr;
            else       reject   = 1'b1;
        end else begin
            case (live_q.phase)
                PH_SCALAR: if (hdr_seen) begin
                    nxt       = '0;
                    nxt.phase = PH_HDR;
                    {nxt.lenset, nxt.ilen16, nxt.predlen, nxt.reglen, nxt.mode} = hdr_fields;
                end
                PH_HDR: if (lenblk_done) begin
                    nxt.phase  = PH_LEN;
                    nxt.lenblk = lenblk_val;
                end
                PH_LEN: if (regblk_done)
                    nxt.phase = PH_EXEC;
                PH_EXEC: begin
                    if (last_done)
                        nxt = '0;
                    else if (op_retire)
                        nxt.optr = advance_ptr(live_q.optr, op_len);
                end
                default: nxt = live_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            live_q    <= nxt;
            illegal_q <= reject;
        end
    end

    assign live    = live_q;
    assign illegal = illegal_q;

    logic quiet;
    assign quiet = !trap_enter && !trap_return && !csr_wr;

    // R3: scalar mode is left only toward the header phase, or by trap return
    a_r3_leave_scalar: assert property (@(posedge clk) disable iff (rst)
        (live_q.phase == PH_SCALAR && !trap_return) |=> (live_q.phase inside {PH_SCALAR, PH_HDR}));
    // R5: entering execution keeps the pointer
    a_r5_keep_ptr: assert property (@(posedge clk) disable iff (rst)
        (live_q.phase == PH_LEN && regblk_done && quiet)
        |=> (live_q.phase == PH_EXEC && live_q.optr == $past(live_q.optr)));
    // R7: group exit discards the whole word
    a_r7_exit_clears: assert property (@(posedge clk) disable iff (rst)
        (live_q.phase == PH_EXEC && last_done && quiet) |=> (live_q == '0));
    // R9: a write outside execution is rejected without side effects
    a_r9_reject_phase: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && !trap_enter && !trap_return && live_q.phase != PH_EXEC)
        |=> (illegal_q && $stable(live_q)));
    // R9: the pulse only follows a write request
    a_r9_pulse_source: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> $past(csr_wr));
    // R11: resume of an executing group rolls back one phase, pointer kept
    a_r11_rollback: assert property (@(posedge clk) disable iff (rst)
        (trap_return && !trap_enter && restore_val.phase == PH_LEN)
        |=> (live_q.phase == PH_LEN && live_q.optr == $past(restore_val.optr)));
    // R13: a trap entry beats any write
    a_r13_trap_first: assert property (@(posedge clk) disable iff (rst)
        trap_enter |=> (live_q == '0 && !illegal_q));
endmodule

// File: rtl/vgrp_state_csr.sv
module vgrp_state_csr
    import vgrp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hdr_seen,
    input  logic [HDR_W-1:0]   hdr_fields,
    input  logic               lenblk_done,
    input  logic [LEN_W-1:0]   lenblk_val,
    input  logic               regblk_done,
    input  logic               op_retire,
    input  logic [OPLEN_W-1:0] op_len,
    input  logic               last_done,
    input  logic               trap_enter,
    input  logic               trap_return,
    input  logic               csr_wr,
    input  logic               wr_use_imm,
    input  logic [PTR_W-1:0]   wr_imm,
    input  logic [XLEN-1:0]    wr_rs1,
    input  logic [BND_W-1:0]   ptr_bound,
    input  logic               sv_wr,
    input  logic [XLEN-1:0]    sv_wdata,
    output logic [XLEN-1:0]    csr_value,
    output logic               grp_active,
    output logic [PTR_W-1:0]   cur_optr,
    output logic               illegal_o,
    output logic [XLEN-1:0]    saved_value
);
    vstate_t            live, saved, restore_val;
    logic               wr_ok;
    logic [PTR_W-1:0]   wr_ptr;

    vgrp_wr_check u_check (
        .phase   (live.phase),
        .use_imm (wr_use_imm),
        .imm     (wr_imm),
        .rs1     (wr_rs1),
        .bound   (ptr_bound),
        .accept  (wr_ok),
        .new_ptr (wr_ptr)
    );

    vgrp_trap_save u_save (
        .clk         (clk),
        .rst         (rst),
        .trap_enter  (trap_enter),
        .live_in     (live),
        .sv_wr       (sv_wr),
        .sv_wdata    (vstate_t'(sv_wdata)),
        .saved       (saved),
        .restore_val (restore_val)
    );

    vgrp_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .hdr_seen    (hdr_seen),
        .hdr_fields  (hdr_fields),
        .lenblk_done (lenblk_done),
        .lenblk_val  (lenblk_val),
        .regblk_done (regblk_done),
        .op_retire   (op_retire),
        .op_len      (op_len),
        .last_done   (last_done),
        .trap_enter  (trap_enter),
        .trap_return (trap_return),
        .restore_val (restore_val),
        .csr_wr      (csr_wr),
        .wr_ok       (wr_ok),
        .wr_ptr      (wr_ptr),
        .live        (live),
        .illegal     (illegal_o)
    );

    assign csr_value   = live;
    assign saved_value = saved;
    assign grp_active  = (live.phase != PH_SCALAR);
    assign cur_optr    = live.optr;

    // R2: the active flag agrees with the top phase bits of the read value
    a_r2_active_flag: assert property (@(posedge clk) disable iff (rst)
        grp_active == (csr_value[31:30] != 2'b00));
    // R8: an in-range execution-phase write leaves every other field alone
    a_r8_fields_kept: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && wr_ok && !trap_enter && !trap_return)
        |=> (csr_value[31:5] == $past(csr_value[31:5]) && !illegal_o));
endmodule

// File: tb/vgrp_state_csr_tb.sv
module vgrp_state_csr_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        hdr_seen, lenblk_done, regblk_done, op_retire, last_done;
    logic        trap_enter, trap_return, csr_wr, wr_use_imm, sv_wr;
    logic [8:0]  hdr_fields;
    logic [15:0] lenblk_val;
    logic [2:0]  op_len;
    logic [4:0]  wr_imm;
    logic [31:0] wr_rs1, sv_wdata;
    logic [5:0]  ptr_bound;
    logic [31:0] csr_value, saved_value;
    logic        grp_active, illegal_o;
    logic [4:0]  cur_optr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_live = '0, m_sv = '0;
    logic        m_ill = 1'b0;
    string       m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    vgrp_state_csr u_dut (
        .clk(clk), .rst(rst), .hdr_seen(hdr_seen), .hdr_fields(hdr_fields),
        .lenblk_done(lenblk_done), .lenblk_val(lenblk_val), .regblk_done(regblk_done),
        .op_retire(op_retire), .op_len(op_len), .last_done(last_done),
        .trap_enter(trap_enter), .trap_return(trap_return), .csr_wr(csr_wr),
        .wr_use_imm(wr_use_imm), .wr_imm(wr_imm), .wr_rs1(wr_rs1), .ptr_bound(ptr_bound),
        .sv_wr(sv_wr), .sv_wdata(sv_wdata), .csr_value(csr_value), .grp_active(grp_active),
        .cur_optr(cur_optr), .illegal_o(illegal_o), .saved_value(saved_value)
    );

    task automatic idle_inputs();
        hdr_seen = 0; lenblk_done = 0; regblk_done = 0; op_retire = 0; last_done = 0;
        trap_enter = 0; trap_return = 0; csr_wr = 0; wr_use_imm = 0; sv_wr = 0;
        hdr_fields = '0; lenblk_val = '0; op_len = 3'd1; wr_imm = '0; wr_rs1 = '0;
        ptr_bound = 6'd32; sv_wdata = '0;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected next state from the requirement text
    task automatic model_step();
        logic [31:0] nl, ns, val;
        logic [1:0]  ph;
        ph = m_live[31:30];
        nl = m_live; ns = m_sv; m_ill = 1'b0; m_tag = "R3";
        if (trap_enter) begin
            ns = m_live; nl = '0; m_tag = "R10";
        end else begin
            if (sv_wr) ns = sv_wdata;
            if (trap_return) begin
                nl = m_sv;
                if (m_sv[31:30] == 2'b11) nl[31:30] = 2'b10;
                m_tag = "R11";
            end else if (csr_wr) begin
                val = wr_use_imm ? {27'd0, wr_imm} : wr_rs1;
                if (ph == 2'b11 && val < {26'd0, ptr_bound}) begin
                    nl[4:0] = val[4:0]; m_tag = "R8";
                end else begin
                    m_ill = 1'b1; m_tag = "R9";
                end
            end else if (ph == 2'b11 && last_done) begin
                nl = '0; m_tag = "R7";
            end else if (ph == 2'b11 && op_retire) begin
                nl[4:0] = m_live[4:0] + {2'b00, op_len}; m_tag = "R6";
            end else if (ph == 2'b10 && regblk_done) begin
                nl[31:30] = 2'b11; m_tag = "R5";
            end else if (ph == 2'b01 && lenblk_done) begin
                nl[31:30] = 2'b10; nl[20:5] = lenblk_val; m_tag = "R4";
            end else if (ph == 2'b00 && hdr_seen) begin
                nl = {2'b01, hdr_fields, 21'd0};
            end
        end
        m_live = nl; m_sv = ns;
    endtask

    task automatic run();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(m_tag, csr_value, m_live);
        chk("R2", {31'd0, grp_active}, {31'd0, m_live[31:30] != 2'b00});
        chk("R2", {27'd0, cur_optr}, {27'd0, m_live[4:0]});
        chk(sv_wr ? "R12" : "R10", saved_value, m_sv);
        chk("R9", {31'd0, illegal_o}, {31'd0, m_ill});
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1-R13 run actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", csr_value, 32'd0);
        chk("R1", saved_value, 32'd0);
        chk("R1", {30'd0, grp_active, illegal_o}, 32'd0);
        rst = 1'b0;

        // Directed walk through a group
        hdr_seen = 1; hdr_fields = 9'b1_101_10_01_1; run();
        chk("R2", {23'd0, csr_value[29:21]}, {23'd0, 9'b1_101_10_01_1});
        hdr_seen = 1; hdr_fields = 9'h0F; run();                 // R3 ignored outside scalar
        lenblk_done = 1; lenblk_val = 16'hBEEF; run();
        chk("R4", {16'd0, csr_value[20:5]}, 32'h0000_BEEF);
        regblk_done = 1; run();                                   // R5
        op_retire = 1; op_len = 3'd3; run();                      // R6
        op_retire = 1; op_len = 3'd2; run();
        csr_wr = 1; wr_use_imm = 1; wr_imm = 5'd9; ptr_bound = 6'd10; run();   // R8 imm
        csr_wr = 1; wr_use_imm = 1; wr_imm = 5'd10; ptr_bound = 6'd10; run();  // R9 at bound
        csr_wr = 1; wr_rs1 = 32'h0001_0003; ptr_bound = 6'd32; run();          // R9 high bits
        csr_wr = 1; wr_rs1 = 32'd31; ptr_bound = 6'd32; run();                 // R8 reg form
        trap_enter = 1; csr_wr = 1; wr_use_imm = 1; run();                     // R13, R10
        csr_wr = 1; wr_use_imm = 1; wr_imm = 5'd1; run();                      // R9 scalar
        sv_wr = 1; sv_wdata = m_sv; sv_wdata[20:5] = 16'h1234; run();          // R12
        trap_return = 1; run();                                                 // R11 rollback
        chk("R11", {30'd0, csr_value[31:30]}, 32'd2);
        chk("R11", {27'd0, cur_optr}, 32'd31);
        regblk_done = 1; run();
        chk("R11", {27'd0, cur_optr}, 32'd31);
        last_done = 1; op_retire = 1; run();                                    // R7
        chk("R7", csr_value, 32'd0);

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            hdr_seen    = ($urandom % 3) == 0;
            hdr_fields  = 9'($urandom);
            lenblk_done = ($urandom % 3) == 0;
            lenblk_val  = 16'($urandom);
            regblk_done = ($urandom % 3) == 0;
            op_retire   = ($urandom % 2) == 0;
            op_len      = 3'(1 + ($urandom % 4));
            last_done   = ($urandom % 12) == 0;
            trap_enter  = ($urandom % 20) == 0;
            trap_return = ($urandom % 14) == 0;
            csr_wr      = ($urandom % 5) == 0;
            wr_use_imm  = ($urandom % 2) == 0;
            wr_imm      = 5'($urandom);
            wr_rs1      = ($urandom % 3 == 0) ? $urandom : 32'($urandom % 40);
            ptr_bound   = 6'($urandom % 33);
            sv_wr       = ($urandom % 16) == 0;
            sv_wdata    = $urandom;
            run();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule